// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block observes the clock and data wires of a two-wire management bus and reports the bus conditions that matter to a host or to an agent on that bus. It never drives either wire. Both inputs are first brought into the system clock domain and cleaned by a short majority-free glitch filter. After that the block finds START and STOP conditions and keeps a busy/idle view of the bus. It raises a pulse when any single clock-low interval runs too long. It also keeps two budgets of clock-stretch time: one summed over a whole message, and one restarted for every byte.

Every time limit is a parameter given in system clock cycles, so one design serves any system clock rate. Stretch time is counted only for the part of each clock-low interval that goes beyond the nominal minimum low period. A separate detector reports when both wires return high after a very long period in which both were held low. Always-powered agents use that event as a power-on indication.

Top module: `twb_timeout_mon`

## Requirements
- R1: Each wire passes through a two-flop synchronizer and then a filter that changes its output only after three consecutive equal samples, so a pulse of one or two system cycles on either wire has no effect on any output.
- R2: A falling data edge while the clock is high gives a one-cycle `start_det` pulse, and a rising data edge while the clock is high gives a one-cycle `stop_det` pulse; `bus_busy` is 1 in the cycle `start_det` is 1 and 0 in the cycle `stop_det` is 1.
- R3: After reset, `bus_busy` and `bus_idle` are both 0, and the two are never 1 at the same time.
- R4: A START seen while busy (repeated START) pulses `start_det`, keeps `bus_busy` at 1 throughout, and does not clear the per-message stretch sum.
- R5: After a STOP, `bus_idle` rises once both wires have stayed high with no transition for `T_BUF_CYC` cycles.
- R6: Whatever came before, `bus_idle` rises and `bus_busy` falls once both wires have stayed high with no transition for `T_HIGH_MAX_CYC` cycles.
- R7: A single clock-low interval longer than `TIMEOUT_CYC` cycles gives exactly one `timeout_abort` pulse; the message is then abandoned (`bus_busy` drops, both stretch sums clear).
- R8: A clock-low interval of L cycles adds max(0, L - `T_LOW_MIN_CYC`) to the stretch sums; only cycles while busy count.
- R9: `slave_ext_violation` sets when the per-message sum exceeds `SEXT_CYC`, and stays set until a START that opens a new message (START while not busy).
- R10: The per-byte sum restarts at every START and at the rising clock edge of each acknowledge bit (the ninth clock of a byte); `master_ext_violation` sets when it exceeds `MEXT_CYC` and clears at the next new message.
- R11: When both wires have been low together for more than `POR_CYC` cycles and then are both high, `por_activity` pulses once.
- R12: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock wire, asynchronous |
| sda_in | input | 1 | Bus data wire, asynchronous |
| bus_busy | output | 1 | A message is in progress |
| bus_idle | output | 1 | The bus is known to be free |
| start_det | output | 1 | One-cycle pulse on START or repeated START |
| stop_det | output | 1 | One-cycle pulse on STOP |
| timeout_abort | output | 1 | One-cycle pulse when one clock-low interval is too long |
| slave_ext_violation | output | 1 | Per-message stretch budget exceeded |
| master_ext_violation | output | 1 | Per-byte stretch budget exceeded |
| por_activity | output | 1 | One-cycle pulse on wires rising after a very long low |

## Verification
Suppose the busy/idle state machine holds a wrong value. It then shows at the ports within one cycle of the next START or STOP, either as a busy flag that drops on a repeated START or as an idle flag that comes too early or too late after STOP. Suppose instead a stretch sum or the byte boundary counter is wrong. Then the violation flags flip at the wrong point, so the bench sets clock-low lengths right at the R8 threshold, one cycle under and one cycle over. A sum that fails to restart between bytes or between messages sets a flag that should have stayed clear as soon as the second byte ends.

// File: rtl/twb_mon_pkg.sv
`timescale 1ns/1ps
package twb_mon_pkg;

    typedef enum logic [1:0] {
        MON_IDLE    = 2'd0,
        MON_BUSY    = 2'd1,
        MON_STOPPED = 2'd2,
        MON_ABANDON = 2'd3
    } mon_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    typedef struct packed {
        logic start;
        logic new_msg;
        logic scl_rise;
    } bus_evt_t;

    // bits needed for a counter that must hold max_val + 1
    function automatic int cnt_w(input int max_val);
        return $clog2(max_val + 2);
    endfunction

    function automatic logic pair_high(input line_pair_t l);
        return l.scl & l.sda;
    endfunction

    function automatic logic pair_low(input line_pair_t l);
        return ~l.scl & ~l.sda;
    endfunction

endpackage

// File: rtl/twb_line_filter.sv
`timescale 1ns/1ps
module twb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic filt_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            hist_q   <= '1;
            filt_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                filt_out <= 1'b1;
            else if (~|hist_q)
                filt_out <= 1'b0;
        end
    end
endmodule

// File: rtl/twb_cond_detect.sv
`timescale 1ns/1ps
module twb_cond_detect
    import twb_mon_pkg::*;
#(
    parameter int T_BUF_CYC      = 16,
    parameter int T_HIGH_MAX_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t lines,
    input  logic       abort_in,
    output mon_state_e state_q,
    output bus_evt_t   evt_q,
    output logic       start_det_q,
    output logic       stop_det_q
);
    localparam int QW = cnt_w(T_HIGH_MAX_CYC);
    localparam logic [QW-1:0] Q_SAT = QW'(T_HIGH_MAX_CYC);
    localparam logic [QW-1:0] Q_BUF = QW'(T_BUF_CYC);

    line_pair_t     prev_q;
    logic [QW-1:0]  quiet_q;
    logic           start_c, stop_c, rise_c;
    mon_state_e     state_d;

    assign start_c = prev_q.scl & lines.scl & prev_q.sda & ~lines.sda;
    assign stop_c  = prev_q.scl & lines.scl & ~prev_q.sda & lines.sda;
    assign rise_c  = ~prev_q.scl & lines.scl;

    always_comb begin
        state_d = state_q;
        if (abort_in)
            state_d = MON_ABANDON;
        else if (start_c)
            state_d = MON_BUSY;
        else if (stop_c)
            state_d = MON_STOPPED;
        else if (state_q == MON_STOPPED && quiet_q >= Q_BUF)
            state_d = MON_IDLE;
        else if (state_q != MON_IDLE && quiet_q == Q_SAT)
            state_d = MON_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '1;
            quiet_q     <= '0;
            state_q     <= MON_ABANDON;
            evt_q       <= '0;
            start_det_q <= 1'b0;
            stop_det_q  <= 1'b0;
        end else begin
            prev_q <= lines;
            if (lines != prev_q || !pair_high(lines))
                quiet_q <= '0;
            else if (quiet_q != Q_SAT)
                quiet_q <= quiet_q + 1'b1;
            state_q          <= state_d;
            evt_q.start      <= start_c;
            evt_q.new_msg    <= start_c & (state_q != MON_BUSY);
            evt_q.scl_rise   <= rise_c;
            start_det_q      <= start_c;
            stop_det_q       <= stop_c;
        end
    end
endmodule

// File: rtl/twb_low_timer.sv
`timescale 1ns/1ps
module twb_low_timer
    import twb_mon_pkg::*;
#(
    parameter int T_LOW_MIN_CYC = 6,
    parameter int TIMEOUT_CYC   = 200,
    parameter int POR_CYC       = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t lines,
    output logic       ext_tick,
    output logic       timeout_q,
    output logic       por_q
);
    localparam int LW = cnt_w(TIMEOUT_CYC + 1);
    localparam logic [LW-1:0] L_SAT = LW'(TIMEOUT_CYC + 1);
    localparam logic [LW-1:0] L_TO  = LW'(TIMEOUT_CYC);
    localparam logic [LW-1:0] L_MIN = LW'(T_LOW_MIN_CYC);
    localparam int PW = cnt_w(POR_CYC);
    localparam logic [PW-1:0] P_LIM = PW'(POR_CYC);

    logic [LW-1:0] low_cnt_q;
    logic [PW-1:0] dark_cnt_q;
    logic          armed_q;

    assign ext_tick = ~lines.scl & (low_cnt_q >= L_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt_q <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= 1'b0;
            if (!lines.scl) begin
                if (low_cnt_q != L_SAT)
                    low_cnt_q <= low_cnt_q + 1'b1;
                if (low_cnt_q == L_TO)
                    timeout_q <= 1'b1;
            end else begin
                low_cnt_q <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dark_cnt_q <= '0;
            armed_q    <= 1'b0;
            por_q      <= 1'b0;
        end else begin
            if (pair_low(lines)) begin
                if (dark_cnt_q != P_LIM)
                    dark_cnt_q <= dark_cnt_q + 1'b1;
            end else begin
                dark_cnt_q <= '0;
            end
            if (pair_high(lines))
                armed_q <= 1'b0;
            else if (pair_low(lines) && dark_cnt_q == P_LIM)
                armed_q <= 1'b1;
            por_q <= armed_q & pair_high(lines);
        end
    end
endmodule

// File: rtl/twb_ext_acc.sv
`timescale 1ns/1ps
module twb_ext_acc
    import twb_mon_pkg::*;
#(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic seg_clear,
    input  logic flag_clear,
    output logic over_q
);
    localparam int AW = cnt_w(LIMIT + 1);
    localparam logic [AW-1:0] A_SAT = AW'(LIMIT + 1);
    localparam logic [AW-1:0] A_LIM = AW'(LIMIT);

    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            over_q <= 1'b0;
        end else begin
            if (seg_clear)
                acc_q <= '0;
            else if (tick && acc_q != A_SAT)
                acc_q <= acc_q + 1'b1;
            if (flag_clear)
                over_q <= 1'b0;
            else if (!seg_clear && tick && acc_q == A_LIM)
                over_q <= 1'b1;
        end
    end
endmodule

// File: rtl/twb_timeout_mon.sv
`timescale 1ns/1ps
module twb_timeout_mon
    import twb_mon_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FILT_LEN       = 3,
    parameter int BYTE_BITS      = 8,
    parameter int T_LOW_MIN_CYC  = 6,
    parameter int T_BUF_CYC      = 16,
    parameter int T_HIGH_MAX_CYC = 64,
    parameter int TIMEOUT_CYC    = 200,
    parameter int SEXT_CYC       = 300,
    parameter int MEXT_CYC       = 120,
    parameter int POR_CYC        = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy,
    output logic bus_idle,
    output logic start_det,
    output logic stop_det,
    output logic timeout_abort,
    output logic slave_ext_violation,
    output logic master_ext_violation,
    output logic por_activity
);
    localparam int NLINES = 2;
    localparam int BW = cnt_w(BYTE_BITS);
    localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_BITS);

    logic [NLINES-1:0] raw_v, filt_v;
    line_pair_t        lines;
    mon_state_e        state;
    bus_evt_t          evt;
    logic              ext_tick, tick_busy, ack_edge;
    logic [BW-1:0]     bit_cnt_q;

    assign raw_v = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        twb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_in  (raw_v[g]),
            .filt_out(filt_v[g])
        );
    end

    assign lines.scl = filt_v[0];
    assign lines.sda = filt_v[1];

    twb_low_timer #(
        .T_LOW_MIN_CYC(T_LOW_MIN_CYC),
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .POR_CYC      (POR_CYC)
    ) u_low (
        .clk      (clk),
        .rst      (rst),
        .lines    (lines),
        .ext_tick (ext_tick),
        .timeout_q(timeout_abort),
        .por_q    (por_activity)
    );

    twb_cond_detect #(
        .T_BUF_CYC     (T_BUF_CYC),
        .T_HIGH_MAX_CYC(T_HIGH_MAX_CYC)
    ) u_cond (
        .clk        (clk),
        .rst        (rst),
        .lines      (lines),
        .abort_in   (timeout_abort),
        .state_q    (state),
        .evt_q      (evt),
        .start_det_q(start_det),
        .stop_det_q (stop_det)
    );

    assign bus_busy  = (state == MON_BUSY);
    assign bus_idle  = (state == MON_IDLE);
    assign tick_busy = ext_tick & bus_busy;
    assign ack_edge  = evt.scl_rise & bus_busy & (bit_cnt_q == ACK_IDX);

    // clock edges since the last byte boundary
    always_ff @(posedge clk) begin
        if (rst)
            bit_cnt_q <= '0;
        else if (evt.start || ack_edge || timeout_abort)
            bit_cnt_q <= '0;
        else if (evt.scl_rise && bus_busy)
            bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    twb_ext_acc #(.LIMIT(SEXT_CYC)) u_msg_acc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_busy),
        .seg_clear (evt.new_msg | timeout_abort),
        .flag_clear(evt.new_msg),
        .over_q    (slave_ext_violation)
    );

    twb_ext_acc #(.LIMIT(MEXT_CYC)) u_byte_acc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_busy),
        .seg_clear (evt.start | ack_edge | timeout_abort),
        .flag_clear(evt.new_msg),
        .over_q    (master_ext_violation)
    );
endmodule

// File: rtl/twb_mon_chk.sv
`timescale 1ns/1ps
module twb_mon_chk (
    input logic clk,
    input logic rst,
    input logic bus_busy,
    input logic bus_idle,
    input logic start_det,
    input logic stop_det,
    input logic timeout_abort,
    input logic slave_ext_violation
);
    // R3
    busy_idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_busy && bus_idle));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |-> bus_busy);

    // R2
    stop_free_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |-> !bus_busy);

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !start_det);

    // R7
    timeout_drop_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_abort |=> !bus_busy);

    // R9
    slave_rise_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slave_ext_violation) |-> $past(bus_busy));
endmodule

bind twb_timeout_mon twb_mon_chk u_chk (
    .clk                (clk),
    .rst                (rst),
    .bus_busy           (bus_busy),
    .bus_idle           (bus_idle),
    .start_det          (start_det),
    .stop_det           (stop_det),
    .timeout_abort      (timeout_abort),
    .slave_ext_violation(slave_ext_violation)
);

// File: tb/sim_twb_timeout_mon.sv
`timescale 1ns/1ps
module sim_twb_timeout_mon;
    localparam int LOWMIN = 6;
    localparam int TBUF   = 16;
    localparam int THMAX  = 64;
    localparam int TOUT   = 200;
    localparam int SEXT   = 300;
    localparam int MEXT   = 120;
    localparam int PORC   = 1000;
    localparam int HI     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_pin = 1'b1;
    logic sda_pin = 1'b1;
    logic bus_busy, bus_idle, start_det, stop_det, timeout_abort;
    logic slave_ext_violation, master_ext_violation, por_activity;

    int n_chk = 0, n_bad = 0;
    int n_start = 0, n_stop = 0, n_to = 0, n_por = 0, n_busy_low = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    twb_timeout_mon #(
        .T_LOW_MIN_CYC(LOWMIN), .T_BUF_CYC(TBUF), .T_HIGH_MAX_CYC(THMAX),
        .TIMEOUT_CYC(TOUT), .SEXT_CYC(SEXT), .MEXT_CYC(MEXT), .POR_CYC(PORC)
    ) u0 (
        .clk(clk), .rst(rst), .scl_in(scl_pin), .sda_in(sda_pin),
        .bus_busy(bus_busy), .bus_idle(bus_idle), .start_det(start_det),
        .stop_det(stop_det), .timeout_abort(timeout_abort),
        .slave_ext_violation(slave_ext_violation),
        .master_ext_violation(master_ext_violation),
        .por_activity(por_activity)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (start_det)     n_start++;
            if (stop_det)      n_stop++;
            if (timeout_abort) n_to++;
            if (por_activity)  n_por++;
            if (!bus_busy)     n_busy_low++;
        end
    end

    function automatic int exp_ext(input int low_len);
        return (low_len > LOWMIN) ? low_len - LOWMIN : 0;
    endfunction

    function automatic int exp_over(input int total, input int lim);
        return (total > lim) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input bit b, input int low_len);
        wait_cyc(1);
        sda_pin = b;
        wait_cyc(low_len - 1);
        scl_pin = 1'b1;
        wait_cyc(HI);
        scl_pin = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, input int low_len);
        for (int i = 7; i >= 0; i--) put_bit(d[i], low_len);
        put_bit(1'b0, low_len);
    endtask

    task automatic do_start();
        if (!scl_pin) begin
            wait_cyc(1);
            sda_pin = 1'b1;
            wait_cyc(LOWMIN - 1);
            scl_pin = 1'b1;
            wait_cyc(HI);
        end else begin
            sda_pin = 1'b1;
            wait_cyc(HI);
        end
        sda_pin = 1'b0;
        wait_cyc(HI);
        scl_pin = 1'b0;
    endtask

    task automatic do_stop();
        wait_cyc(1);
        sda_pin = 1'b0;
        wait_cyc(LOWMIN - 1);
        scl_pin = 1'b1;
        wait_cyc(HI);
        sda_pin = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int s0, s1, s2, b0, tot, nb, ll;
        logic [7:0] d;
        void'($urandom(32'd4242));

        wait_cyc(5);
        // R12 outputs during reset
        chk("R12 busy in reset", int'(bus_busy), 0);
        chk("R12 flags in reset", int'({bus_idle, start_det, stop_det, timeout_abort,
            slave_ext_violation, master_ext_violation, por_activity}), 0);
        rst = 1'b0;
        wait_cyc(20);
        chk("R3 no idle yet", int'(bus_idle), 0);
        chk("R3 no busy yet", int'(bus_busy), 0);
        wait_cyc(80);
        chk("R6 idle from long high", int'(bus_idle), 1);

        // R1 short glitch on data while clock high
        s0 = n_start;
        sda_pin = 1'b0; wait_cyc(2); sda_pin = 1'b1;
        wait_cyc(20);
        chk("R1 glitch start count", n_start - s0, 0);
        chk("R1 glitch idle kept", int'(bus_idle), 1);

        // R2 START
        s0 = n_start;
        do_start();
        wait_cyc(4);
        chk("R2 start pulse", n_start - s0, 1);
        chk("R2 busy after start", int'(bus_busy), 1);
        chk("R3 not idle when busy", int'(bus_idle), 0);
        put_byte(8'hA5, LOWMIN);
        chk("R8 nominal lows no slave flag", int'(slave_ext_violation), 0);
        chk("R8 nominal lows no master flag", int'(master_ext_violation), 0);

        // R4 repeated START keeps busy
        s0 = n_start; b0 = n_busy_low;
        do_start();
        put_byte(8'h3C, LOWMIN);
        chk("R4 repeated start pulse", n_start - s0, 1);
        chk("R4 busy held", n_busy_low - b0, 0);

        // R5 STOP then short free time
        s0 = n_stop;
        do_stop();
        wait_cyc(10);
        chk("R2 stop pulse", n_stop - s0, 1);
        chk("R2 busy off after stop", int'(bus_busy), 0);
        chk("R5 not idle early", int'(bus_idle), 0);
        wait_cyc(30);
        chk("R5 idle after free time", int'(bus_idle), 1);

        // R9 + R4: sum carries across repeated START
        do_start();
        tot = 0;
        for (int k = 0; k < 3; k++) begin put_byte(8'h5A, LOWMIN + 10); tot += 9 * exp_ext(LOWMIN + 10); end
        wait_cyc(3);
        chk("R9 under budget", int'(slave_ext_violation), exp_over(tot, SEXT));
        do_start();
        for (int k = 0; k < 2; k++) begin put_byte(8'hC3, LOWMIN + 10); tot += 9 * exp_ext(LOWMIN + 10); end
        wait_cyc(3);
        chk("R4 R9 sum kept over repeated start", int'(slave_ext_violation), exp_over(tot, SEXT));
        chk("R10 byte budget untouched", int'(master_ext_violation), 0);
        do_stop(); wait_cyc(40);
        chk("R9 flag held after stop", int'(slave_ext_violation), 1);
        do_start(); wait_cyc(4);
        chk("R9 flag cleared by new message", int'(slave_ext_violation), 0);
        tot = 0;
        for (int k = 0; k < 3; k++) begin put_byte(8'h81, LOWMIN + 10); tot += 9 * exp_ext(LOWMIN + 10); end
        wait_cyc(3);
        chk("R9 fresh message sum", int'(slave_ext_violation), exp_over(tot, SEXT));
        do_stop(); wait_cyc(40);

        // R8 R10 exact threshold on one low interval
        s1 = n_to;
        do_start();
        put_bit(1'b1, LOWMIN + MEXT);
        put_byte(8'h00, LOWMIN);
        wait_cyc(3);
        chk("R8 excess equal to byte limit", int'(master_ext_violation), exp_over(MEXT, MEXT));
        do_stop(); wait_cyc(40);
        do_start();
        put_bit(1'b1, LOWMIN + MEXT + 1);
        wait_cyc(3);
        chk("R8 R10 excess one over byte limit", int'(master_ext_violation),
            exp_over(exp_ext(LOWMIN + MEXT + 1), MEXT));
        chk("R9 single long low under message limit", int'(slave_ext_violation),
            exp_over(exp_ext(LOWMIN + MEXT + 1), SEXT));
        chk("R7 no timeout below limit", n_to - s1, 0);
        put_byte(8'hFF, LOWMIN);
        do_stop(); wait_cyc(40);

        // R10 byte sum restarts at each acknowledge
        do_start();
        for (int k = 0; k < 2; k++) put_byte(8'h66, LOWMIN + 10);
        wait_cyc(3);
        chk("R10 per-byte restart", int'(master_ext_violation), exp_over(9 * exp_ext(LOWMIN + 10), MEXT));
        do_stop(); wait_cyc(40);

        // R7 clock held low too long
        s1 = n_to;
        do_start();
        put_byte(8'h12, LOWMIN);
        wait_cyc(TOUT + 60);
        chk("R7 one timeout pulse", n_to - s1, 1);
        chk("R7 busy dropped", int'(bus_busy), 0);
        scl_pin = 1'b1; wait_cyc(HI); sda_pin = 1'b1;
        wait_cyc(THMAX + 30);
        chk("R6 idle after abandon", int'(bus_idle), 1);

        // R11 long dark period
        s2 = n_por;
        sda_pin = 1'b0; wait_cyc(HI); scl_pin = 1'b0;
        wait_cyc(PORC + 200);
        scl_pin = 1'b1; wait_cyc(HI); sda_pin = 1'b1;
        wait_cyc(30);
        chk("R11 power-on pulse", n_por - s2, 1);
        s2 = n_por;
        sda_pin = 1'b0; wait_cyc(HI); scl_pin = 1'b0;
        wait_cyc(PORC / 2);
        scl_pin = 1'b1; wait_cyc(HI); sda_pin = 1'b1;
        wait_cyc(THMAX + 30);
        chk("R11 short dark period", n_por - s2, 0);

        // random messages with near-nominal timing
        s0 = n_start; s1 = n_stop;
        tot = 0;
        for (int m = 0; m < 6; m++) begin
            nb = 1 + int'($urandom_range(2, 0));
            do_start();
            for (int k = 0; k < nb; k++) begin
                d  = 8'($urandom());
                ll = LOWMIN + int'($urandom_range(4, 0));
                put_byte(d, ll);
                if (9 * exp_ext(ll) > tot) tot = 9 * exp_ext(ll);
            end
            do_stop();
            wait_cyc(40);
        end
        chk("R2 random start count", n_start - s0, 6);
        chk("R2 random stop count", n_stop - s1, 6);
        chk("R10 random no byte flag", int'(master_ext_violation), exp_over(tot, MEXT));
        chk("R9 random no message flag", int'(slave_ext_violation), exp_over(3 * tot, SEXT));
        chk("R5 random ends idle", int'(bus_idle), 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule